// File: doc/BRIEF.md
# PRBS Data Randomizer with Selectable Polynomial

This block whitens a serial bit stream by adding (XOR) a pseudo-random bit to every valid data bit. The bits come from a linear feedback shift register that can run as either a 15-stage or a 6-stage generator. The generator is chosen at run time. Its start state comes from a seed input, and the seed is reloaded at the start of every frame. Because the scrambling is additive, a receiver that runs the same generator from the same seed recovers the data.

The randomizer sits next to an external forward-error-correction stage. A routing bit places the randomizer either ahead of that stage or behind it. The block feeds the external stage through a transmit pair and takes its result back through a receive pair. An enable bit turns the whitening off. With whitening off, the bits still flow through with the same one-cycle delay.

Top module: `prbs_randomizer`

## Requirements
- R1: While reset is asserted, and after it is released, `out_valid` and `fec_tx_valid` (when driven by the randomizer) are 0. The generator state is all zeros and the 15-stage generator is active. Until the first frame start, enabled data therefore passes unchanged.
- R2: The randomizer stage has one cycle of latency. Its output valid equals its input valid one clock earlier, and its output bit changes only on cycles that carry a valid input bit.
- R3: With the long generator active (`cfg_poly_sel` = 0, polynomial x^15 + x^14 + 1), the feedback bit is f = s[14] XOR s[13]. Each valid bit leaves as d XOR f, and the state becomes {s[13:0], f}.
- R4: With the short generator active (`cfg_poly_sel` = 1, polynomial x^6 + x^5 + 1), f = s[5] XOR s[4] and the state becomes {s[4:0], f}. Only `cfg_seed[5:0]` is loaded, and state bits 14..6 stay zero.
- R5: A `frame_start` pulse loads the seed and adopts `cfg_poly_sel`, whether or not the block is enabled. If a valid bit arrives in the same cycle, that bit is the first of the new frame and is scrambled from the new seed.
- R6: A change of `cfg_poly_sel` without `frame_start` has no effect until the next `frame_start`.
- R7: The generator advances only on cycles with a valid input bit while enabled. Idle cycles leave it unchanged.
- R8: With `cfg_enable` = 0, every valid bit leaves unchanged and the generator does not advance.
- R9: With `cfg_order` = 0, input goes through the randomizer to `fec_tx_*`, and `fec_rx_*` drives the output directly. With `cfg_order` = 1, input drives `fec_tx_*` directly in the same cycle, and `fec_rx_*` goes through the randomizer to the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_enable | input | 1 | 1 = whiten, 0 = pass bits unchanged |
| cfg_poly_sel | input | 1 | 0 = 15-stage generator, 1 = 6-stage generator; adopted at frame start |
| cfg_seed | input | 15 | Generator start state (low 6 bits only for the short generator) |
| cfg_order | input | 1 | 0 = randomizer before FEC, 1 = FEC before randomizer |
| frame_start | input | 1 | One-cycle pulse that reloads the seed |
| in_valid | input | 1 | Input bit qualifier |
| in_bit | input | 1 | Serial input data |
| out_valid | output | 1 | Output bit qualifier |
| out_bit | output | 1 | Serial output data |
| fec_tx_valid | output | 1 | Qualifier toward the FEC stage |
| fec_tx_bit | output | 1 | Data toward the FEC stage |
| fec_rx_valid | input | 1 | Qualifier from the FEC stage |
| fec_rx_bit | input | 1 | Data from the FEC stage |

## Verification
The bound checker checks the following on every cycle:
- the randomizer stage's one-cycle valid latency;
- that the state is frozen on idle cycles and while disabled;
- the unchanged passage of bits while disabled;
- that the active generator is held between frame starts;
- the zero upper state bits under the short generator;
- the seed loaded by a frame start without data.

Only the bench scenarios can show the following, because they need a reference generator running across many bits:
- the actual pseudo-random sequences;
- the seed being used by a bit that coincides with a frame start;
- the effect of a generator change in mid-frame;
- the routing through the external stage in both orders.

// File: rtl/prbs_rand_pkg.sv
package prbs_rand_pkg;

  typedef enum logic {
    POLY_LONG  = 1'b0,
    POLY_SHORT = 1'b1
  } poly_sel_e;

  typedef enum logic {
    ORDER_RAND_FIRST = 1'b0,
    ORDER_FEC_FIRST  = 1'b1
  } order_e;

  typedef struct packed {
    logic valid;
    logic data;
  } bit_beat_t;

endpackage

// File: rtl/prbs_rst_sync.sv
module prbs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/prbs_lfsr_step.sv
module prbs_lfsr_step #(
  parameter int USED_W = 15,
  parameter int TAP_HI = 14,
  parameter int TAP_LO = 13
) (
  input  logic [USED_W-1:0] cur_state,
  output logic              feedback,
  output logic [USED_W-1:0] nxt_state
);

  always_comb begin
    feedback  = cur_state[TAP_HI] ^ cur_state[TAP_LO];
    nxt_state = {cur_state[USED_W-2:0], feedback};
  end

endmodule

// File: rtl/prbs_scrambler_core.sv
module prbs_scrambler_core
  import prbs_rand_pkg::*;
#(
  parameter int STATE_W      = 15,
  parameter int SHORT_W      = 6,
  parameter int LONG_TAP_HI  = 14,
  parameter int LONG_TAP_LO  = 13,
  parameter int SHORT_TAP_HI = 5,
  parameter int SHORT_TAP_LO = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  poly_sel_e          poly_sel,
  input  logic [STATE_W-1:0] seed,
  input  logic               frame_start,
  input  logic               in_valid,
  input  logic               in_bit,
  output logic               out_valid,
  output logic               out_bit,
  output logic [STATE_W-1:0] lfsr_state,
  output poly_sel_e          active_poly
);

  localparam int NUM_POLY = 2;
  localparam int PAD_W    = STATE_W - SHORT_W;

  logic [STATE_W-1:0] state_q, state_d, eff_state, seed_eff;
  poly_sel_e          poly_q, poly_d, eff_poly;
  logic               state_en, adv, fb_sel;
  logic               out_valid_q, out_bit_q, out_bit_d;
  logic [NUM_POLY-1:0] fb_v;
  logic [STATE_W-1:0]  nxt_v [NUM_POLY];

  // one next-state generator per selectable polynomial
  for (genvar g = 0; g < NUM_POLY; g++) begin : g_poly
    localparam int USED = (g == 0) ? STATE_W : SHORT_W;
    localparam int THI  = (g == 0) ? LONG_TAP_HI : SHORT_TAP_HI;
    localparam int TLO  = (g == 0) ? LONG_TAP_LO : SHORT_TAP_LO;
    logic [USED-1:0] nxt_raw;
    prbs_lfsr_step #(
      .USED_W (USED),
      .TAP_HI (THI),
      .TAP_LO (TLO)
    ) u_step (
      .cur_state (eff_state[USED-1:0]),
      .feedback  (fb_v[g]),
      .nxt_state (nxt_raw)
    );
    assign nxt_v[g] = STATE_W'(nxt_raw);
  end

  // next-state logic
  always_comb begin
    if (poly_sel == POLY_SHORT) begin
      seed_eff = {{PAD_W{1'b0}}, seed[SHORT_W-1:0]};
    end else begin
      seed_eff = seed;
    end
    eff_state = frame_start ? seed_eff : state_q;
    eff_poly  = frame_start ? poly_sel : poly_q;
    adv       = in_valid & enable;
    fb_sel    = (eff_poly == POLY_SHORT) ? fb_v[1] : fb_v[0];
    if (adv) begin
      state_d = (eff_poly == POLY_SHORT) ? nxt_v[1] : nxt_v[0];
    end else begin
      state_d = eff_state;
    end
    poly_d    = eff_poly;
    state_en  = frame_start | adv;
    out_bit_d = in_bit ^ (adv & fb_sel);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      poly_q  <= POLY_LONG;
    end else if (state_en) begin
      state_q <= state_d;
      poly_q  <= poly_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
    end else begin
      out_valid_q <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_bit_q <= 1'b0;
    end else if (in_valid) begin
      out_bit_q <= out_bit_d;
    end
  end

  assign out_valid   = out_valid_q;
  assign out_bit     = out_bit_q;
  assign lfsr_state  = state_q;
  assign active_poly = poly_q;

endmodule

// File: rtl/prbs_order_mux.sv
module prbs_order_mux
  import prbs_rand_pkg::*;
(
  input  order_e    order,
  input  bit_beat_t src_in,
  input  bit_beat_t scr_out,
  input  bit_beat_t fec_rx,
  output bit_beat_t scr_in,
  output bit_beat_t fec_tx,
  output bit_beat_t dst_out
);

  always_comb begin
    case (order)
      ORDER_FEC_FIRST: begin
        fec_tx  = src_in;
        scr_in  = fec_rx;
        dst_out = scr_out;
      end
      default: begin
        scr_in  = src_in;
        fec_tx  = scr_out;
        dst_out = fec_rx;
      end
    endcase
  end

endmodule

// File: rtl/prbs_randomizer.sv
module prbs_randomizer
  import prbs_rand_pkg::*;
#(
  parameter int STATE_W      = 15,
  parameter int SHORT_W      = 6,
  parameter int LONG_TAP_HI  = 14,
  parameter int LONG_TAP_LO  = 13,
  parameter int SHORT_TAP_HI = 5,
  parameter int SHORT_TAP_LO = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_enable,
  input  logic               cfg_poly_sel,
  input  logic [STATE_W-1:0] cfg_seed,
  input  logic               cfg_order,
  input  logic               frame_start,
  input  logic               in_valid,
  input  logic               in_bit,
  output logic               out_valid,
  output logic               out_bit,
  output logic               fec_tx_valid,
  output logic               fec_tx_bit,
  input  logic               fec_rx_valid,
  input  logic               fec_rx_bit
);

  logic               rst_n_sync;
  bit_beat_t          src_in, scr_in, scr_out, fec_rx, fec_tx, dst_out;
  logic               scr_in_valid, scr_in_bit, scr_out_valid, scr_out_bit;
  logic [STATE_W-1:0] lfsr_state;
  poly_sel_e          active_poly;

  prbs_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  assign src_in       = '{valid: in_valid, data: in_bit};
  assign fec_rx       = '{valid: fec_rx_valid, data: fec_rx_bit};
  assign scr_out      = '{valid: scr_out_valid, data: scr_out_bit};
  assign scr_in_valid = scr_in.valid;
  assign scr_in_bit   = scr_in.data;

  prbs_order_mux u_order (
    .order   (order_e'(cfg_order)),
    .src_in  (src_in),
    .scr_out (scr_out),
    .fec_rx  (fec_rx),
    .scr_in  (scr_in),
    .fec_tx  (fec_tx),
    .dst_out (dst_out)
  );

  prbs_scrambler_core #(
    .STATE_W      (STATE_W),
    .SHORT_W      (SHORT_W),
    .LONG_TAP_HI  (LONG_TAP_HI),
    .LONG_TAP_LO  (LONG_TAP_LO),
    .SHORT_TAP_HI (SHORT_TAP_HI),
    .SHORT_TAP_LO (SHORT_TAP_LO)
  ) u_core (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .enable      (cfg_enable),
    .poly_sel    (poly_sel_e'(cfg_poly_sel)),
    .seed        (cfg_seed),
    .frame_start (frame_start),
    .in_valid    (scr_in_valid),
    .in_bit      (scr_in_bit),
    .out_valid   (scr_out_valid),
    .out_bit     (scr_out_bit),
    .lfsr_state  (lfsr_state),
    .active_poly (active_poly)
  );

  assign fec_tx_valid = fec_tx.valid;
  assign fec_tx_bit   = fec_tx.data;
  assign out_valid    = dst_out.valid;
  assign out_bit      = dst_out.data;

endmodule

// File: rtl/prbs_randomizer_chk.sv
module prbs_randomizer_chk #(
  parameter int STATE_W = 15,
  parameter int SHORT_W = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_start,
  input logic               cfg_enable,
  input logic               cfg_poly_sel,
  input logic [STATE_W-1:0] cfg_seed,
  input logic               scr_in_valid,
  input logic               scr_in_bit,
  input logic               scr_out_valid,
  input logic               scr_out_bit,
  input logic [STATE_W-1:0] lfsr_state,
  input logic               active_poly
);

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    scr_in_valid |=> scr_out_valid); // R2

  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !scr_in_valid |=> (!scr_out_valid && $stable(scr_out_bit))); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!scr_in_valid && !frame_start) |=> $stable(lfsr_state)); // R7

  AST_BYPASS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (scr_in_valid && !cfg_enable && !frame_start)
      |=> ($stable(lfsr_state) && scr_out_bit == $past(scr_in_bit))); // R8

  AST_POLY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(active_poly)); // R6

  AST_SHORT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    active_poly |-> (lfsr_state[STATE_W-1:SHORT_W] == '0)); // R4

  AST_LONG_SEED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !scr_in_valid && !cfg_poly_sel)
      |=> (lfsr_state == $past(cfg_seed) && !active_poly)); // R5

  AST_SHORT_SEED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !scr_in_valid && cfg_poly_sel)
      |=> (lfsr_state[SHORT_W-1:0] == $past(cfg_seed[SHORT_W-1:0]) && active_poly)); // R5

endmodule

bind prbs_randomizer prbs_randomizer_chk #(
  .STATE_W (STATE_W),
  .SHORT_W (SHORT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n_sync),
  .frame_start   (frame_start),
  .cfg_enable    (cfg_enable),
  .cfg_poly_sel  (cfg_poly_sel),
  .cfg_seed      (cfg_seed),
  .scr_in_valid  (scr_in_valid),
  .scr_in_bit    (scr_in_bit),
  .scr_out_valid (scr_out_valid),
  .scr_out_bit   (scr_out_bit),
  .lfsr_state    (lfsr_state),
  .active_poly   (active_poly)
);

// File: tb/prbs_randomizer_test.sv
module prbs_randomizer_test;

  logic        clk, rst_n;
  logic        cfg_enable, cfg_poly_sel, cfg_order;
  logic [14:0] cfg_seed;
  logic        frame_start, in_valid, in_bit;
  logic        out_valid, out_bit, fec_tx_valid, fec_tx_bit;
  logic        fec_rx_valid, fec_rx_bit;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [14:0] m_state;
  logic        m_poly;
  bit          pre_frame;

  prbs_randomizer uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_enable   (cfg_enable),
    .cfg_poly_sel (cfg_poly_sel),
    .cfg_seed     (cfg_seed),
    .cfg_order    (cfg_order),
    .frame_start  (frame_start),
    .in_valid     (in_valid),
    .in_bit       (in_bit),
    .out_valid    (out_valid),
    .out_bit      (out_bit),
    .fec_tx_valid (fec_tx_valid),
    .fec_tx_bit   (fec_tx_bit),
    .fec_rx_valid (fec_rx_valid),
    .fec_rx_bit   (fec_rx_bit)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // stand-in FEC stage: one register, inverted data
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fec_rx_valid <= 1'b0;
      fec_rx_bit   <= 1'b0;
    end else begin
      fec_rx_valid <= fec_tx_valid;
      fec_rx_bit   <= ~fec_tx_bit;
    end
  end

  function automatic logic [14:0] b_mask(logic [14:0] s, logic sh);
    return sh ? {9'b0, s[5:0]} : s;
  endfunction

  function automatic logic b_fb(logic [14:0] s, logic sh);
    return sh ? (s[5] ^ s[4]) : (s[14] ^ s[13]);
  endfunction

  function automatic logic [14:0] b_next(logic [14:0] s, logic sh);
    return sh ? {9'b0, s[4:0], b_fb(s, sh)} : {s[13:0], b_fb(s, sh)};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // one bit cycle: drive at negedge, predict, sample after the edge
  task automatic cyc(input logic fs, input logic v, input logic b, input string tag_in);
    logic        s_v, s_b, e_poly, e_bit, ov, ob;
    logic [14:0] e_state;
    string       tag;
    @(negedge clk);
    frame_start = fs;
    in_valid    = v;
    in_bit      = b;
    #1;
    if (cfg_order) begin
      s_v = fec_rx_valid;
      s_b = fec_rx_bit;
      chk(fec_tx_valid == v && fec_tx_bit == b, "R9 fec_tx direct",
          {fec_tx_valid, fec_tx_bit}, {v, b});
    end else begin
      s_v = v;
      s_b = b;
    end
    e_state = fs ? b_mask(cfg_seed, cfg_poly_sel) : m_state;
    e_poly  = fs ? cfg_poly_sel : m_poly;
    if (fs) pre_frame = 0;
    if (s_v && cfg_enable) begin
      e_bit   = s_b ^ b_fb(e_state, e_poly);
      m_state = b_next(e_state, e_poly);
    end else begin
      e_bit   = s_b;
      m_state = e_state;
    end
    m_poly = e_poly;
    if (tag_in != "")               tag = tag_in;
    else if (pre_frame)             tag = "R1";
    else if (!cfg_enable)           tag = "R8";
    else if (cfg_poly_sel != m_poly) tag = "R6";
    else if (m_poly)                tag = "R4";
    else                            tag = "R3";
    @(posedge clk);
    #1;
    if (cfg_order) begin
      ov = out_valid;
      ob = out_bit;
    end else begin
      ov = fec_tx_valid;
      ob = fec_tx_bit;
      chk(out_valid == fec_rx_valid && out_bit == fec_rx_bit, "R9 out from fec_rx",
          {out_valid, out_bit}, {fec_rx_valid, fec_rx_bit});
    end
    chk(ov == s_v, "R2 valid latency", ov, s_v);
    if (s_v) chk(ob == e_bit, tag, ob, e_bit);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    rst_n = 0; cfg_enable = 1; cfg_poly_sel = 0; cfg_order = 0;
    cfg_seed = 15'h0; frame_start = 0; in_valid = 1; in_bit = 1;
    m_state = '0; m_poly = 0; pre_frame = 1;
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && fec_tx_valid == 0, "R1 in reset", {out_valid, fec_tx_valid}, 0);
    in_valid = 0;
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(fec_tx_valid == 0 && out_valid == 0, "R1 after release", {out_valid, fec_tx_valid}, 0);

    // R1: zero state before first frame: data unchanged
    for (int i = 0; i < 6; i++) cyc(0, 1, i[0], "R1");

    // R5: frame start together with the first bit, long generator, all-ones seed
    cfg_seed = 15'h7FFF;
    cyc(1, 1, 0, "R5");
    for (int i = 0; i < 20; i++) cyc(0, 1, 0, "R3");
    // R5: frame start without data, then bits
    cfg_seed = 15'h1234;
    cyc(1, 0, 0, "R5");
    for (int i = 0; i < 10; i++) cyc(0, 1, i[1], "R5");

    // R7: idle gaps keep the sequence in step
    for (int i = 0; i < 4; i++) cyc(0, 1, 1, "R7");
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, "R7");
    for (int i = 0; i < 4; i++) cyc(0, 1, 1, "R7");

    // R4: short generator, seed with upper bits set (must be ignored)
    cfg_poly_sel = 1; cfg_seed = 15'h7FC1;
    cyc(1, 1, 0, "R4");
    for (int i = 0; i < 70; i++) cyc(0, 1, 0, "R4");

    // R6: mid-frame switch back to long has no effect yet
    cfg_poly_sel = 0;
    for (int i = 0; i < 12; i++) cyc(0, 1, 0, "R6");
    cyc(1, 1, 0, "R6");
    for (int i = 0; i < 8; i++) cyc(0, 1, 0, "R3");

    // R8: disabled: unchanged bits, generator holds
    cfg_enable = 0;
    for (int i = 0; i < 8; i++) cyc(0, 1, i[0], "R8");
    cfg_enable = 1;
    for (int i = 0; i < 8; i++) cyc(0, 1, 0, "R8");
    // R5: seed still loads while disabled
    cfg_enable = 0; cfg_seed = 15'h0F0F;
    cyc(1, 0, 0, "R5");
    cfg_enable = 1;
    for (int i = 0; i < 8; i++) cyc(0, 1, 1, "R5");

    // R9: FEC first, then back
    cfg_order = 1;
    cyc(1, 1, 1, "R9");
    for (int i = 0; i < 20; i++) cyc(0, 1, i[2], "R9");
    cfg_order = 0;
    for (int i = 0; i < 4; i++) cyc(0, 1, 1, "R9");

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic fs, v, b;
      fs = ($urandom % 40) == 0;
      if (fs) begin
        cfg_seed = 15'($urandom);
        if (($urandom % 2) == 0) cfg_poly_sel = ~cfg_poly_sel;
      end else if (($urandom % 60) == 0) begin
        cfg_poly_sel = ~cfg_poly_sel;
      end
      if (($urandom % 120) == 0) cfg_enable = ~cfg_enable;
      if (($urandom % 300) == 0) cfg_order = ~cfg_order;
      v = ($urandom % 4) != 0;
      b = 1'($urandom);
      cyc(fs, v, b, "");
    end

    done = 1;
    summary();
    $finish;
  end

endmodule